// File: doc/BRIEF.md
# I2C Bus Event Flag Logic

This block turns the per-cycle event strobes of an I2C bus engine into sticky interrupt flags for a controller that can work as bus master or as slave. It also holds the controller's role bit. The engine reports these events: arbitration loss, a missing acknowledge, a STOP, the ninth clock of a byte, the end of an address phase with the received address, a byte transfer together with the running byte count, and the level of a low clock line. Configuration inputs choose the clock-low timeout, the byte-count threshold and the automatic-stop mode.

The block tests each raw event against the current role, the bus phase or the configuration before it sets a flag. A flag stays set until its bit on the clear vector is driven. The clear vector comes from a vector generator or from a software write. The role bit is set by a request from the engine. Any loss of arbitration returns the role bit to slave.

Top module: `i2c_evt_flags`

## Requirements
- R1: After reset every flag is 0 and the role bit `is_master` is 0 (slave). A pulse on `mst_req` sets `is_master` at the next edge.
- R2: A pulse on `arb_lost` sets flag bit 0 (arbitration lost) and clears `is_master` at the same edge, and this wins over a `mst_req` in the same cycle.
- R3: If an address match is reported while `is_master` is 1, this is an arbitration loss. Flag bit 0 is set, `is_master` is cleared, and flag bit 5 is not set.
- R4: Flag bit 1 (not-acknowledge) is set by `nack_rx` only while `is_master` is 1. It is ignored in slave role.
- R5: Flag bit 2 (clock-low timeout) is set at the edge after `scl_low` has been sampled 1 on T+1 consecutive edges, where T = 2^(TO_BASE+to_sel-1) for `to_sel` values 1, 2 and 3. With `to_sel` = 0 it never sets. It sets at most once per low period.
- R6: Flag bit 3 (ninth bit) is set by `bit9_tick` only when `addr_phase` is 0. Address bytes never set it.
- R7: Flag bit 4 (byte count) is set by `byte_done` when `byte_cnt` equals `byte_thr` and `auto_stop` is 2'b01 or 2'b10. With `auto_stop` at 2'b00 or 2'b11 it never sets.
- R8: Flag bit 5 (START with own address) is set only in slave role, when `addr_valid` is pulsed and `rx_addr` equals `own_addr`. Bits of `addr_mask` that are 1 are don't-care, and only while `mask_en` is 1.
- R9: Flag bit 6 (STOP) is set by `stop_det` in both slave and master role.
- R10: Each flag is sticky: it stays 1 until the matching bit of `flag_clr` is 1, and the clear takes effect at the next edge.
- R11: When a flag's set event and its clear bit arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mst_req | input | 1 | Strobe: enter master role |
| arb_lost | input | 1 | Strobe: arbitration lost on the bus |
| nack_rx | input | 1 | Strobe: acknowledge expected but not received |
| stop_det | input | 1 | Strobe: STOP condition detected |
| bit9_tick | input | 1 | Strobe: ninth clock of a byte |
| addr_phase | input | 1 | 1 while the current byte is an address byte |
| addr_valid | input | 1 | Strobe: address after START received in `rx_addr` |
| rx_addr | input | ADDR_W | Received address |
| own_addr | input | ADDR_W | Own slave address |
| addr_mask | input | ADDR_W | Don't-care mask, 1 = ignore bit |
| mask_en | input | 1 | Apply `addr_mask` |
| scl_low | input | 1 | Clock line is currently held low |
| to_sel | input | 2 | Timeout select, 0 = off |
| byte_done | input | 1 | Strobe: a byte finished |
| byte_cnt | input | CNT_W | Bytes transferred so far |
| byte_thr | input | CNT_W | Byte-count threshold |
| auto_stop | input | 2 | Automatic-stop mode |
| flag_clr | input | 7 | Per-flag clear |
| flags | output | 7 | Sticky flags, bit order as in R2 to R9 |
| is_master | output | 1 | 1 = master role |

## Verification
The assertions run on every cycle. They check that an arbitration loss always demotes the role, that the role-gated and phase-gated flags rise only when their condition held in the cycle before, that set events win over clears, and that flags never drop without a clear. Only the bench scenarios can show the exact timeout threshold for each `to_sel` value and that the timeout sets once per low period. The same holds for the address masking arithmetic and for the byte-count response to each `auto_stop` code.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
    localparam int FLAG_N  = 7;
    localparam int FL_AL   = 0;
    localparam int FL_NACK = 1;
    localparam int FL_CLTO = 2;
    localparam int FL_BIT9 = 3;
    localparam int FL_BCNT = 4;
    localparam int FL_STT  = 5;
    localparam int FL_STP  = 6;

    typedef logic [FLAG_N-1:0] flag_vec_t;

    typedef struct packed {
        flag_vec_t flags;
        logic      master;
    } evt_state_t;
endpackage

// File: rtl/i2c_evt_addr_match.sv
module i2c_evt_addr_match #(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ADDR_W-1:0] addr_mask,
    input  logic              mask_en,
    input  logic              addr_valid,
    output logic              hit
);
    logic [ADDR_W-1:0] care;

    always_comb begin
        care = mask_en ? ~addr_mask : '1;
        hit  = addr_valid && (((rx_addr ^ own_addr) & care) == '0);
    end
endmodule

// File: rtl/i2c_evt_low_timer.sv
module i2c_evt_low_timer #(
    parameter int TO_BASE = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_low,
    input  logic [1:0] to_sel,
    output logic       expired
);
    localparam int LOW_W = TO_BASE + 3;

    logic [LOW_W-1:0] cnt_d, cnt_q;
    logic [LOW_W-1:0] limit;

    always_comb begin
        limit = '0;
        if (to_sel != 2'd0)
            limit = LOW_W'(1) << (TO_BASE + int'(to_sel) - 1);
        cnt_d = cnt_q;
        if (!scl_low)
            cnt_d = '0;
        else if (cnt_q != '1)
            cnt_d = cnt_q + LOW_W'(1);
        expired = scl_low && (to_sel != 2'd0) && (cnt_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2c_evt_cond.sv
module i2c_evt_cond
    import i2c_evt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             master,
    input  logic             arb_lost,
    input  logic             nack_rx,
    input  logic             stop_det,
    input  logic             bit9_tick,
    input  logic             addr_phase,
    input  logic             addr_hit,
    input  logic             low_expired,
    input  logic             byte_done,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic [CNT_W-1:0] byte_thr,
    input  logic [1:0]       auto_stop,
    output flag_vec_t        set_vec,
    output logic             demote
);
    logic cnt_mode;

    always_comb begin
        cnt_mode = (auto_stop == 2'b01) || (auto_stop == 2'b10);
        demote   = arb_lost || (addr_hit && master);
        set_vec  = '0;
        set_vec[FL_AL]   = demote;
        set_vec[FL_NACK] = nack_rx && master;
        set_vec[FL_CLTO] = low_expired;
        set_vec[FL_BIT9] = bit9_tick && !addr_phase;
        set_vec[FL_BCNT] = byte_done && cnt_mode && (byte_cnt == byte_thr);
        set_vec[FL_STT]  = addr_hit && !master;
        set_vec[FL_STP]  = stop_det;
    end
endmodule

// File: rtl/i2c_evt_flags.sv
module i2c_evt_flags
    import i2c_evt_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int CNT_W   = 8,
    parameter int TO_BASE = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mst_req,
    input  logic              arb_lost,
    input  logic              nack_rx,
    input  logic              stop_det,
    input  logic              bit9_tick,
    input  logic              addr_phase,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ADDR_W-1:0] addr_mask,
    input  logic              mask_en,
    input  logic              scl_low,
    input  logic [1:0]        to_sel,
    input  logic              byte_done,
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic [CNT_W-1:0]  byte_thr,
    input  logic [1:0]        auto_stop,
    input  logic [6:0]        flag_clr,
    output logic [6:0]        flags,
    output logic              is_master
);
    evt_state_t st_d, st_q;
    logic       addr_hit;
    logic       low_expired;
    flag_vec_t  set_vec;
    logic       demote;

    i2c_evt_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .rx_addr   (rx_addr),
        .own_addr  (own_addr),
        .addr_mask (addr_mask),
        .mask_en   (mask_en),
        .addr_valid(addr_valid),
        .hit       (addr_hit)
    );

    i2c_evt_low_timer #(.TO_BASE(TO_BASE)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_low(scl_low),
        .to_sel (to_sel),
        .expired(low_expired)
    );

    i2c_evt_cond #(.CNT_W(CNT_W)) u_cond (
        .master     (st_q.master),
        .arb_lost   (arb_lost),
        .nack_rx    (nack_rx),
        .stop_det   (stop_det),
        .bit9_tick  (bit9_tick),
        .addr_phase (addr_phase),
        .addr_hit   (addr_hit),
        .low_expired(low_expired),
        .byte_done  (byte_done),
        .byte_cnt   (byte_cnt),
        .byte_thr   (byte_thr),
        .auto_stop  (auto_stop),
        .set_vec    (set_vec),
        .demote     (demote)
    );

    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~flag_clr) | set_vec;
        if (demote)
            st_d.master = 1'b0;
        else if (mst_req)
            st_d.master = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags     = st_q.flags;
    assign is_master = st_q.master;
endmodule

// File: rtl/i2c_evt_flags_chk.sv
module i2c_evt_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mst_req,
    input logic       arb_lost,
    input logic       nack_rx,
    input logic       stop_det,
    input logic       bit9_tick,
    input logic       addr_phase,
    input logic       scl_low,
    input logic [1:0] to_sel,
    input logic [1:0] auto_stop,
    input logic [6:0] flag_clr,
    input logic [6:0] flags,
    input logic       is_master
);
    a_r2_arb_demotes: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |=> (!is_master && flags[0]));

    a_r4_nack_master_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[1]) |-> $past(is_master && nack_rx));

    a_r5_timeout_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[2]) |-> $past(scl_low && (to_sel != 2'd0)));

    a_r6_bit9_data_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[3]) |-> $past(bit9_tick && !addr_phase));

    a_r7_bcnt_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[4]) |-> $past((auto_stop == 2'b01) || (auto_stop == 2'b10)));

    a_r8_stt_slave_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[5]) |-> $past(!is_master));

    a_r1_role_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_req && !arb_lost && !is_master) |=> (is_master || flags[0]));

    a_r11_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && flag_clr[6]) |=> flags[6]);

    for (genvar i = 0; i < 7; i++) begin : g_sticky
        a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !flag_clr[i]) |=> flags[i]);
    end
endmodule

bind i2c_evt_flags i2c_evt_flags_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mst_req   (mst_req),
    .arb_lost  (arb_lost),
    .nack_rx   (nack_rx),
    .stop_det  (stop_det),
    .bit9_tick (bit9_tick),
    .addr_phase(addr_phase),
    .scl_low   (scl_low),
    .to_sel    (to_sel),
    .auto_stop (auto_stop),
    .flag_clr  (flag_clr),
    .flags     (flags),
    .is_master (is_master)
);

// File: tb/i2c_evt_flags_test.sv
module i2c_evt_flags_test;
    localparam int ADDR_W = 10;
    localparam int CNT_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mst_req = 0, arb_lost = 0, nack_rx = 0, stop_det = 0;
    logic              bit9_tick = 0, addr_phase = 0, addr_valid = 0, mask_en = 0;
    logic [ADDR_W-1:0] rx_addr = '0, own_addr = '0, addr_mask = '0;
    logic              scl_low = 0, byte_done = 0;
    logic [1:0]        to_sel = 0, auto_stop = 0;
    logic [CNT_W-1:0]  byte_cnt = '0, byte_thr = '0;
    logic [6:0]        flag_clr = '0;
    logic [6:0]        flags;
    logic              is_master;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    logic erole = 1'b0;

    typedef struct {
        logic [6:0] f;
        logic       m;
        string      tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    i2c_evt_flags uut (
        .clk(clk), .rst_n(rst_n), .mst_req(mst_req), .arb_lost(arb_lost),
        .nack_rx(nack_rx), .stop_det(stop_det), .bit9_tick(bit9_tick),
        .addr_phase(addr_phase), .addr_valid(addr_valid), .rx_addr(rx_addr),
        .own_addr(own_addr), .addr_mask(addr_mask), .mask_en(mask_en),
        .scl_low(scl_low), .to_sel(to_sel), .byte_done(byte_done),
        .byte_cnt(byte_cnt), .byte_thr(byte_thr), .auto_stop(auto_stop),
        .flag_clr(flag_clr), .flags(flags), .is_master(is_master)
    );

    task automatic summary_and_finish();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 100000", cycles);
            summary_and_finish();
        end
    end

    // monitor: compares outputs with queued expectations after each edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                tests++;
                if (flags !== e.f || is_master !== e.m) begin
                    fails++;
                    $display("FAIL %s: actual flags=%h role=%b expected flags=%h role=%b",
                             e.tag, flags, is_master, e.f, e.m);
                end
            end
        end
    end

    // driver: one clock edge with current inputs, optional expectation
    task automatic step(input logic chk, input logic [6:0] ef, input string tag);
        @(posedge clk);
        if (chk) q.push_back('{f: ef, m: erole, tag: tag});
        @(negedge clk);
        mst_req = 0; arb_lost = 0; nack_rx = 0; stop_det = 0;
        bit9_tick = 0; addr_valid = 0; byte_done = 0; flag_clr = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, "");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tests++;
        if (flags !== 7'h00 || is_master !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: actual flags=%h role=%b expected flags=00 role=0", flags, is_master);
        end
        rst_n = 1'b1;
        step(1, 7'h00, "R1 idle after reset");

        mst_req = 1; erole = 1; step(1, 7'h00, "R1 master request");
        nack_rx = 1; step(1, 7'h02, "R4 nack as master");
        arb_lost = 1; mst_req = 1; erole = 0; step(1, 7'h03, "R2 arbitration loss");
        nack_rx = 1; step(1, 7'h03, "R4 nack ignored as slave");
        step(1, 7'h03, "R10 flags sticky");
        flag_clr = 7'h7F; step(1, 7'h00, "R10 clear all");

        bit9_tick = 1; addr_phase = 1; step(1, 7'h00, "R6 address byte ignored");
        bit9_tick = 1; addr_phase = 0; step(1, 7'h08, "R6 data byte ninth clock");

        byte_cnt = 8'd5; byte_thr = 8'd5;
        auto_stop = 2'b00; byte_done = 1; step(1, 7'h08, "R7 mode 00 ignored");
        auto_stop = 2'b01; byte_done = 1; step(1, 7'h18, "R7 mode 01 match");
        flag_clr = 7'h10; auto_stop = 2'b10; byte_cnt = 8'd4; byte_done = 1;
        step(1, 7'h08, "R7 count mismatch");
        byte_cnt = 8'd5; byte_done = 1; step(1, 7'h18, "R7 mode 10 match");
        flag_clr = 7'h10; auto_stop = 2'b11; byte_done = 1; step(1, 7'h08, "R7 mode 11 ignored");
        flag_clr = 7'h7F; step(1, 7'h00, "R10 clear");

        own_addr = 10'h02A; rx_addr = 10'h02B; addr_mask = 10'h001; mask_en = 0;
        addr_valid = 1; step(1, 7'h00, "R8 mismatch without mask");
        mask_en = 1; addr_valid = 1; step(1, 7'h20, "R8 match with mask");
        rx_addr = 10'h02E; addr_valid = 1; step(1, 7'h20, "R8 masked mismatch");
        stop_det = 1; step(1, 7'h60, "R9 stop as slave");
        flag_clr = 7'h7F; step(1, 7'h00, "R10 clear");

        mst_req = 1; erole = 1; step(1, 7'h00, "R1 master again");
        rx_addr = 10'h02B; addr_valid = 1; erole = 0; step(1, 7'h01, "R3 addressed while master");
        flag_clr = 7'h7F; mst_req = 1; erole = 1; step(1, 7'h00, "R1 master request");
        stop_det = 1; step(1, 7'h40, "R9 stop as master");
        stop_det = 1; flag_clr = 7'h40; step(1, 7'h40, "R11 set beats clear");
        flag_clr = 7'h40; step(1, 7'h00, "R10 clear only");

        to_sel = 2'd1; scl_low = 1;
        idle(1023);
        step(1, 7'h00, "R5 threshold not yet");
        step(1, 7'h04, "R5 timeout sel 1");
        idle(50);
        flag_clr = 7'h04; step(1, 7'h00, "R5 clear during low");
        idle(100);
        step(1, 7'h00, "R5 once per low period");
        scl_low = 0; step(1, 7'h00, "R5 release");

        to_sel = 2'd0; scl_low = 1;
        idle(5000);
        step(1, 7'h00, "R5 disabled");
        scl_low = 0; step(1, 7'h00, "R5 release");

        to_sel = 2'd2; scl_low = 1;
        idle(2047);
        step(1, 7'h00, "R5 sel 2 not yet");
        step(1, 7'h04, "R5 timeout sel 2");
        scl_low = 0; step(1, 7'h04, "R10 sticky after release");

        @(negedge clk);
        @(negedge clk);
        summary_and_finish();
    end
endmodule